// File: doc/BRIEF.md
# Double-Data-Rate Burst Bus Memory Target

This block is the responder on a byte-wide, double-data-rate burst bus. It sits in front of a small internal array of 16-bit words. A host lowers chip select, toggles the bus clock, and sends a 48-bit command/address header on the first six clock edges. The header gives the direction, the space (memory array or register space), the burst ordering and the starting word address. The block then counts a fixed number of idle latency clocks. For a read it returns words one byte per clock edge, together with a strobe that it toggles itself. For a write it takes one word for every two clock edges and stores it in the array. Raising chip select ends the transaction at once, even in the middle of a burst.

The bus clock is not used as a clock. The block runs on its own faster system clock and oversamples the bus clock, chip select and data lines, treating every change of the bus clock as one transfer edge. Every bus-side output is therefore a plain register in one clock domain. The host must hold each bus clock level for at least two system clocks.

Top module: `hbd_target`

## Requirements
- R1: The header bytes arrive on the first six bus clock edges after chip select falls, most significant byte first, and form header bits [47:0]. Bit 47 set selects a read and clear selects a write. Bit 46 set selects register space. Bit 45 set selects linear ordering and clear selects wrapped ordering. The start word address is the low ADDR_W bits of {header[44:16], header[2:0]}.
- R2: bus_rds and bus_dq_oe are low while chip select is high, during the six header edges and during the latency edges.
- R3: The first data edge is the first rising bus clock edge after LAT full bus clocks, counted from the clock that follows the last header edge. On a read, each rising data edge drives the word's upper byte with bus_rds high. Each falling data edge drives its lower byte with bus_rds low. bus_dq_oe stays high through the data phase.
- R4: In linear ordering the word address rises by one per word and rolls over only at the end of the array.
- R5: In wrapped ordering the word address rises by one per word inside an aligned group of WRAP_WORDS words (16 by default), so the step after the last word of the group returns to the group's first word.
- R6: On a write, the byte on a rising data edge is the upper byte and the byte on the following falling edge is the lower byte. The assembled word is stored at the current burst address, which then advances by R4 or R5.
- R7: A read from register space returns the constant FILL (16'hC3A5 by default) for every word.
- R8: A write to register space changes no word of the array.
- R9: Chip select going high clears bus_rds, bus_dq_oe and bus_dq_out on the next system clock, whatever the phase. The next transaction is decoded from its first header byte.
- R10: A bus clock edge seen in the same system clock as chip select going high is ignored, so a word whose falling edge coincides with it is not written.
- R11: During and after reset, bus_rds, bus_dq_oe and bus_dq_out are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs_n | input | 1 | Active-low chip select from the host |
| bus_ck | input | 1 | Bus clock from the host; every level change is a transfer edge |
| bus_dq_in | input | 8 | Header and write data byte from the host |
| bus_dq_out | output | 8 | Read data byte to the host |
| bus_dq_oe | output | 1 | High while the block drives read data |
| bus_rds | output | 1 | Read strobe, toggled with each read byte |

## Verification
Ending a transaction and completing a write word can fall in the same system clock. This happens when the host lowers the bus clock for the lower byte of a word and raises chip select on the same cycle. The bench provokes it in a write burst by sending the upper byte of a second word, then lowering the clock and deselecting together. It judges the outcome by reading both addresses back: the first word must hold the new value and the second must keep its earlier content. The same idea is applied to reads and the latency count: chip select is raised mid-burst and mid-latency, and the strobe and output enable must drop on the next cycle and the following transaction must decode cleanly.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

   localparam int HDR_BYTES = 6;
   localparam int HDR_BITS  = 8 * HDR_BYTES;

   typedef enum logic [1:0] {
      PH_CMD  = 2'd0,
      PH_LAT  = 2'd1,
      PH_DATA = 2'd2
   } phase_t;

   typedef struct packed {
      logic        rd;
      logic        regsp;
      logic        linear;
      logic [31:0] waddr;
   } hdr_t;

   function automatic hdr_t hdr_decode(input logic [HDR_BITS-1:0] h);
      hdr_t d;
      d.rd     = h[47];
      d.regsp  = h[46];
      d.linear = h[45];
      d.waddr  = {h[44:16], h[2:0]};
      return d;
   endfunction

endpackage

// File: rtl/hbd_ca_shift.sv
module hbd_ca_shift #(
   parameter int BYTES = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               en,
   input  logic [7:0]         din,
   output logic [8*BYTES-1:0] hdr
);
   localparam int BITS = 8 * BYTES;

   logic [BITS-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
      end else if (clr) begin
         sh_q <= '0;
      end else if (en) begin
         sh_q <= {sh_q[BITS-9:0], din};
      end
   end

   assign hdr = sh_q;
endmodule

// File: rtl/hbd_addr_seq.sv
module hbd_addr_seq #(
   parameter int ADDR_W = 8,
   parameter int WRAP_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld,
   input  logic [ADDR_W-1:0] start,
   input  logic              linear,
   input  logic              adv,
   output logic [ADDR_W-1:0] addr
);
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] lin_next;
   logic [ADDR_W-1:0] wrap_next;

   assign lin_next = addr_q + ADDR_W'(1);

   generate
      if (WRAP_W < ADDR_W) begin : g_group
         assign wrap_next = {addr_q[ADDR_W-1:WRAP_W], addr_q[WRAP_W-1:0] + WRAP_W'(1)};
      end else begin : g_whole
         assign wrap_next = lin_next;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (ld) begin
         addr_q <= start;
      end else if (adv) begin
         addr_q <= linear ? lin_next : wrap_next;
      end
   end

   assign addr = addr_q;
endmodule

// File: rtl/hbd_word_mem.sv
module hbd_word_mem #(
   parameter int ADDR_W = 8,
   parameter int DW     = 16
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DW-1:0]     wdata,
   output logic [DW-1:0]     rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DW-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         cells[addr] <= wdata;
      end
   end

   assign rdata = cells[addr];
endmodule

// File: rtl/hbd_target.sv
module hbd_target #(
   parameter int          ADDR_W     = 8,
   parameter int          LAT        = 6,
   parameter int          WRAP_WORDS = 16,
   parameter logic [15:0] FILL       = 16'hC3A5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_cs_n,
   input  logic       bus_ck,
   input  logic [7:0] bus_dq_in,
   output logic [7:0] bus_dq_out,
   output logic       bus_dq_oe,
   output logic       bus_rds
);
   import hbd_pkg::*;

   localparam int WRAP_W    = $clog2(WRAP_WORDS);
   localparam int LAT_EDGES = 2 * LAT;
   localparam int LCW       = $clog2(LAT_EDGES + 1);
   localparam int IW        = $clog2(HDR_BYTES);

   generate
      if (LAT < 3 || LAT > 16) begin : g_bad_lat
         $error("hbd_target: LAT must lie in 3..16");
      end
      if (WRAP_WORDS < 2 || (1 << WRAP_W) != WRAP_WORDS || WRAP_W > ADDR_W) begin : g_bad_wrap
         $error("hbd_target: WRAP_WORDS must be a power of two between 2 and the array depth");
      end
      if (ADDR_W < 4 || ADDR_W > 31) begin : g_bad_addr
         $error("hbd_target: ADDR_W must lie in 4..31");
      end
   endgenerate

   logic              ck_q;
   logic              ck_edge;
   phase_t            phase_q;
   logic [IW-1:0]     byte_idx;
   logic [LCW-1:0]    lat_cnt;
   logic              half_q;
   logic [7:0]        hi_hold;
   logic [7:0]        lo_hold;
   logic [HDR_BITS-1:0] hdr48;
   hdr_t              dec;
   logic [15:0]       mem_rdata;
   logic [15:0]       rd_word;
   logic [ADDR_W-1:0] seq_addr;
   logic              seq_ld;
   logic              seq_adv;
   logic              mem_we;
   logic              in_cmd;
   logic              in_data;
   logic              unused_bits;

   assign ck_edge = !bus_cs_n && (bus_ck ^ ck_q);
   assign in_cmd  = (phase_q == PH_CMD);
   assign in_data = (phase_q == PH_DATA);
   assign dec     = hdr_decode(hdr48);
   assign rd_word = dec.regsp ? FILL : mem_rdata;
   assign seq_ld  = (phase_q == PH_LAT);
   assign seq_adv = ck_edge && in_data && half_q;
   assign mem_we  = seq_adv && !dec.rd && !dec.regsp;

   assign unused_bits = ^{hdr48[15:3], dec.waddr[31:ADDR_W]};

   hbd_ca_shift #(
      .BYTES (HDR_BYTES)
   ) u_ca_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (bus_cs_n),
      .en    (ck_edge && in_cmd),
      .din   (bus_dq_in),
      .hdr   (hdr48)
   );

   hbd_addr_seq #(
      .ADDR_W (ADDR_W),
      .WRAP_W (WRAP_W)
   ) u_addr_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (seq_ld),
      .start  (dec.waddr[ADDR_W-1:0]),
      .linear (dec.linear),
      .adv    (seq_adv),
      .addr   (seq_addr)
   );

   hbd_word_mem #(
      .ADDR_W (ADDR_W),
      .DW     (16)
   ) u_word_mem (
      .clk   (clk),
      .we    (mem_we),
      .addr  (seq_addr),
      .wdata ({hi_hold, bus_dq_in}),
      .rdata (mem_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ck_q       <= 1'b0;
         phase_q    <= PH_CMD;
         byte_idx   <= '0;
         lat_cnt    <= '0;
         half_q     <= 1'b0;
         hi_hold    <= '0;
         lo_hold    <= '0;
         bus_rds    <= 1'b0;
         bus_dq_oe  <= 1'b0;
         bus_dq_out <= '0;
      end else begin
         ck_q <= bus_ck;
         if (bus_cs_n) begin
            phase_q    <= PH_CMD;
            byte_idx   <= '0;
            lat_cnt    <= '0;
            half_q     <= 1'b0;
            bus_rds    <= 1'b0;
            bus_dq_oe  <= 1'b0;
            bus_dq_out <= '0;
         end else if (ck_edge) begin
            unique case (phase_q)
               PH_CMD: begin
                  if (byte_idx == IW'(HDR_BYTES - 1)) begin
                     phase_q <= PH_LAT;
                     lat_cnt <= '0;
                  end else begin
                     byte_idx <= byte_idx + IW'(1);
                  end
               end
               PH_LAT: begin
                  if (lat_cnt == LCW'(LAT_EDGES - 1)) begin
                     phase_q <= PH_DATA;
                     half_q  <= 1'b0;
                  end else begin
                     lat_cnt <= lat_cnt + LCW'(1);
                  end
               end
               PH_DATA: begin
                  if (!half_q) begin
                     half_q  <= 1'b1;
                     hi_hold <= bus_dq_in;
                     if (dec.rd) begin
                        bus_dq_out <= rd_word[15:8];
                        lo_hold    <= rd_word[7:0];
                        bus_rds    <= 1'b1;
                        bus_dq_oe  <= 1'b1;
                     end
                  end else begin
                     half_q <= 1'b0;
                     if (dec.rd) begin
                        bus_dq_out <= lo_hold;
                        bus_rds    <= 1'b0;
                     end
                  end
               end
               default: phase_q <= PH_CMD;
            endcase
         end
      end
   end

endmodule

// File: rtl/hbd_target_chk.sv
module hbd_target_chk #(
   parameter int ADDR_W = 8,
   parameter int WRAP_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_cs_n,
   input logic              bus_rds,
   input logic              bus_dq_oe,
   input logic              ck_edge,
   input logic              in_cmd,
   input logic              in_data,
   input logic [2:0]        byte_idx,
   input logic              mem_we,
   input logic              reg_space,
   input logic              seq_adv,
   input logic              seq_ld,
   input logic              seq_linear,
   input logic [ADDR_W-1:0] seq_addr
);

   // R2
   cs_idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_cs_n |=> (!bus_rds && !bus_dq_oe));

   // R2
   strobe_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_data |-> !bus_rds);

   // R3
   strobe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(bus_rds) || ($fell(bus_rds) && !$past(bus_cs_n))) |-> $past(ck_edge));

   // R3
   strobe_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rds |-> bus_dq_oe);

   // R9
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_cs_n |=> (in_cmd && byte_idx == 3'd0));

   // R8
   regwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !reg_space);

   // R10
   cs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !bus_cs_n);

   generate
      if (WRAP_W < ADDR_W) begin : g_wrap_chk
         // R5
         wrap_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (seq_adv && !seq_ld && !seq_linear) |=> $stable(seq_addr[ADDR_W-1:WRAP_W]));
      end
   endgenerate

endmodule

bind hbd_target hbd_target_chk #(
   .ADDR_W (ADDR_W),
   .WRAP_W (WRAP_W)
) i_hbd_target_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_cs_n   (bus_cs_n),
   .bus_rds    (bus_rds),
   .bus_dq_oe  (bus_dq_oe),
   .ck_edge    (ck_edge),
   .in_cmd     (in_cmd),
   .in_data    (in_data),
   .byte_idx   (3'(byte_idx)),
   .mem_we     (mem_we),
   .reg_space  (dec.regsp),
   .seq_adv    (seq_adv),
   .seq_ld     (seq_ld),
   .seq_linear (dec.linear),
   .seq_addr   (seq_addr)
);

// File: tb/test_hbd_target.sv
module test_hbd_target;

   localparam int          LAT  = 6;
   localparam int          HP   = 3;
   localparam logic [15:0] FILL = 16'hC3A5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1;
   logic       ck = 1'b0;
   logic [7:0] dq_in = '0;
   logic [7:0] dq_out;
   logic       dq_oe;
   logic       rds;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [15:0] model [256];

   always #2.5 clk = ~clk;

   hbd_target #(
      .ADDR_W (8),
      .LAT    (LAT),
      .WRAP_WORDS (16),
      .FILL   (FILL)
   ) i_hbd_target (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_cs_n   (cs_n),
      .bus_ck     (ck),
      .bus_dq_in  (dq_in),
      .bus_dq_out (dq_out),
      .bus_dq_oe  (dq_oe),
      .bus_rds    (rds)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] nxt(input logic [7:0] a, input bit lin);
      return lin ? a + 8'd1 : {a[7:4], a[3:0] + 4'd1};
   endfunction

   function automatic logic [47:0] mk_hdr(input bit rd, input bit rg, input bit lin, input logic [7:0] a);
      logic [47:0] h = '0;
      h[47] = rd; h[46] = rg; h[45] = lin;
      h[20:16] = a[7:3];
      h[2:0] = a[2:0];
      return h;
   endfunction

   task automatic step(input logic [7:0] b, output logic [7:0] q, output logic r, output logic oe);
      @(negedge clk);
      ck = ~ck;
      dq_in = b;
      repeat (HP - 1) @(negedge clk);
      q = dq_out; r = rds; oe = dq_oe;
   endtask

   // Header and latency; R1/R2 checked on every edge
   task automatic open_txn(input logic [47:0] h, input int lat_edges);
      logic [7:0] q; logic r, oe;
      @(negedge clk); cs_n = 1'b0;
      repeat (2) @(negedge clk);
      for (int i = 0; i < 6; i++) begin
         step(h[47-8*i -: 8], q, r, oe);
         chk(!r && !oe, "R2 header phase quiet", {r, oe}, 0);
      end
      for (int i = 0; i < lat_edges; i++) begin
         step(8'h00, q, r, oe);
         chk(!r && !oe, "R2 latency phase quiet", {r, oe}, 0);
      end
   endtask

   task automatic close_txn();
      @(negedge clk); cs_n = 1'b1;
      @(negedge clk);
      chk(!rds && !dq_oe && dq_out == 0, "R9 deselect clears outputs", {rds, dq_oe, dq_out}, 0);
      repeat (2) @(negedge clk);
   endtask

   task automatic write_burst(input logic [7:0] a0, input bit lin, input bit rg, input int n, input logic [7:0] seed);
      logic [7:0] q; logic r, oe; logic [7:0] a = a0;
      open_txn(mk_hdr(1'b0, rg, lin, a0), 2 * LAT);
      for (int i = 0; i < n; i++) begin
         logic [15:0] w = {seed, 8'(i * 17 + 3)};
         step(w[15:8], q, r, oe);
         step(w[7:0], q, r, oe);
         if (!rg) model[a] = w;
         a = nxt(a, lin);
      end
      close_txn();
   endtask

   task automatic read_burst(input logic [7:0] a0, input bit lin, input bit rg, input int n, input string req);
      logic [7:0] q; logic r, oe; logic [7:0] a = a0; logic [15:0] e;
      open_txn(mk_hdr(1'b1, rg, lin, a0), 2 * LAT);
      for (int i = 0; i < n; i++) begin
         e = rg ? FILL : model[a];
         step(8'h00, q, r, oe);
         chk(q == e[15:8] && r && oe, {req, " R3 upper byte, strobe high"}, {r, oe, q}, {2'b11, e[15:8]});
         step(8'h00, q, r, oe);
         chk(q == e[7:0] && !r && oe, {req, " R3 lower byte, strobe low"}, {r, oe, q}, {2'b01, e[7:0]});
         a = nxt(a, lin);
      end
      close_txn();
   endtask

   task automatic t_reset();
      chk(!rds && !dq_oe && dq_out == 0, "R11 reset outputs", {rds, dq_oe, dq_out}, 0);
   endtask

   task automatic t_linear();
      write_burst(8'h10, 1'b1, 1'b0, 8, 8'h4E);
      read_burst(8'h10, 1'b1, 1'b0, 8, "R1 R4 R6 linear");
   endtask

   task automatic t_wrap();
      write_burst(8'h30, 1'b1, 1'b0, 16, 8'h71);
      write_burst(8'h3D, 1'b0, 1'b0, 6, 8'h92);
      read_burst(8'h3E, 1'b0, 1'b0, 20, "R5 wrapped");
   endtask

   task automatic t_array_end();
      write_burst(8'hFE, 1'b1, 1'b0, 4, 8'hB6);
      read_burst(8'hFE, 1'b1, 1'b0, 4, "R4 array rollover");
   endtask

   task automatic t_regspace();
      read_burst(8'h10, 1'b1, 1'b1, 4, "R7 register read");
      write_burst(8'h10, 1'b1, 1'b1, 2, 8'hEE);
      read_burst(8'h10, 1'b1, 1'b0, 2, "R8 register write discarded");
   endtask

   task automatic t_abort();
      read_burst(8'h10, 1'b1, 1'b0, 2, "R9 abort mid burst");
      open_txn(mk_hdr(1'b1, 1'b0, 1'b1, 8'h14), 4);
      close_txn();
      read_burst(8'h12, 1'b1, 1'b0, 3, "R9 fresh after abort");
   endtask

   task automatic t_coincide();
      logic [7:0] q; logic r, oe;
      logic [15:0] w0 = 16'h1357;
      logic [15:0] keep = model[8'h31];
      open_txn(mk_hdr(1'b0, 1'b0, 1'b1, 8'h30), 2 * LAT);
      step(w0[15:8], q, r, oe);
      step(w0[7:0], q, r, oe);
      model[8'h30] = w0;
      step(8'hAB, q, r, oe);
      @(negedge clk);
      ck = ~ck; dq_in = 8'hCD; cs_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(model[8'h31] == keep, "R10 model unchanged", model[8'h31], keep);
      read_burst(8'h30, 1'b1, 1'b0, 2, "R10 coincident edge ignored");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_linear();
      t_wrap();
      t_array_end();
      t_regspace();
      t_abort();
      t_coincide();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule